// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the configuration front end of a multi-channel clock distribution path. A host drives three wires: a serial clock, a serial data line and a latch strobe. The block samples all three with its own system clock. Each 32-bit word is shifted in most-significant bit first. When the latch strobe rises, the word is written into one of a small set of configuration registers. The low four bits of the word give the address and the upper 28 bits carry the data.

The bank has eight per-channel registers and one global register. A separate address holds the output voltage-boost bit. Each channel register holds an output path mode, an enable, a divide code and a delay code. The global register holds the input select, a global output enable and a power-down bit. All fields come out as flat decoded vectors for the channel logic. A soft reset bit in register 0 returns the whole bank to its power-on values. A framing error flag records any latch strobe that arrives before a full word has been shifted in.

The word assembler is a two-state machine. **SHIFT** accepts bits on serial clock rising edges while the latch is low. **HELD** ignores the serial clock until the latch falls. It has three transitions:
- **ACCEPT**: SHIFT to HELD when the latch rises after 32 or more bits. It issues the write strobe.
- **REJECT**: SHIFT to HELD when the latch rises after fewer than 32 bits. It sets the error flag.
- **REARM**: HELD to SHIFT when the latch falls. It clears the bit count.

Top module: `serial_cfg_bank`

## Requirements
- R1: Data bits are taken in on each rising edge of the serial clock while the latch is low, most significant bit first, so the first bit sent becomes word bit 31.
- R2: A rising latch edge after at least 32 bits writes the word into the register addressed by bits 3:0. The new fields appear on the outputs in the system-clock cycle after the edge is seen.
- R3: Addresses 0 to 7 select channel 0 to 7. In a channel word, mode is bits 18:17, enable is bit 16, divide code is bits 15:8 and delay code is bits 7:4. Channel n occupies slice n of each output vector.
- R4: Address 14 is the global register: input select is bit 28, global enable is bit 27 and power down is bit 26.
- R5: Address 9 holds the voltage-boost flag in bit 16.
- R6: After reset: every mode is 0, every enable is 0, every divide code is 1, every delay code is 0, input select is 0, global enable is 1, power down is 0, boost is 0 and the error flag is 0.
- R7: A write to address 0 with bit 31 set restores every register to its R6 value and ignores the other bits of that word.
- R8: Writes to addresses 8, 10 to 13 and 15 change no output.
- R9: A rising latch edge after fewer than 32 bits writes nothing and sets the error flag. The flag stays set until the reset input is asserted.
- R10: When more than 32 bits are shifted before the latch, the last 32 bits form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Latch strobe; its rising edge commits the word |
| ch_mode | output | 16 | Path mode, 2 bits per channel |
| ch_en | output | 8 | Per-channel output enable |
| ch_div | output | 64 | Divide code, 8 bits per channel |
| ch_dly | output | 32 | Delay code, 4 bits per channel |
| in_sel | output | 1 | Input clock select |
| glob_en | output | 1 | Global output enable |
| pwr_down | output | 1 | Device power down |
| vboost | output | 1 | Output voltage boost |
| frame_err | output | 1 | Sticky short-frame error |

## Verification
The bench covers several corner cases, each with a specific failure mode:
- **Short frame.** A 31-bit frame addressed to a channel must leave the bank untouched. A design that commits short words would corrupt that channel and leave the error flag low.
- **40-bit frame.** A design that keeps the first bits instead of the last ones would decode the wrong address.
- **Soft reset with other fields set.** The reset word also carries nonzero channel fields, so a design that applies those fields alongside the reset shows them on channel 0.
- **Unused address.** A word of all ones sent to an unused address would show up in some channel if the address decode were wrong.

Distinct patterns are used in each field so that a swapped bit position stands out.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NCH     = 8;
    localparam int MODE_W  = 2;
    localparam int DIV_W   = 8;
    localparam int DLY_W   = 4;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    localparam logic [ADDR_W-1:0] VB_ADDR  = 4'd9;
    localparam logic [ADDR_W-1:0] GLB_ADDR = 4'd14;

    localparam int MODE_LSB = 17;
    localparam int EN_BIT   = 16;
    localparam int DIV_LSB  = 8;
    localparam int DLY_LSB  = 4;
    localparam int SRST_BIT = 31;
    localparam int INSEL_BIT = 28;
    localparam int GEN_BIT   = 27;
    localparam int PD_BIT    = 26;
    localparam int VB_BIT    = 16;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
        logic [DIV_W-1:0]  div;
        logic [DLY_W-1:0]  dly;
    } chan_cfg_t;

    typedef struct packed {
        logic insel;
        logic gen;
        logic pd;
    } glob_cfg_t;

    localparam chan_cfg_t CHAN_DEFAULT = '{mode: '0, en: 1'b0, div: DIV_W'(1), dly: '0};
    localparam glob_cfg_t GLOB_DEFAULT = '{insel: 1'b0, gen: 1'b1, pd: 1'b0};

    typedef enum logic [0:0] {
        S_SHIFT = 1'b0,
        S_HELD  = 1'b1
    } asm_state_t;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sdata,
    input  logic              le_rise,
    input  logic              le_fall,
    output logic [WORD_W-1:0] word,
    output logic              wr_stb,
    output logic              frame_err
);
    asm_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              err_set;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_SHIFT;
        else        state <= state_nx;
    end

    // Next state and strobes
    always_comb begin
        state_nx = state;
        wr_stb   = 1'b0;
        err_set  = 1'b0;
        unique case (state)
            S_SHIFT: if (le_rise) begin
                state_nx = S_HELD;
                if (cnt == CNT_W'(WORD_W)) wr_stb  = 1'b1;   // ACCEPT
                else                       err_set = 1'b1;   // REJECT
            end
            S_HELD: if (le_fall) state_nx = S_SHIFT;         // REARM
            default: state_nx = S_SHIFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word      <= '0;
            cnt       <= '0;
            frame_err <= 1'b0;
        end else begin
            if (state == S_SHIFT && sclk_rise) begin
                word <= {word[WORD_W-2:0], sdata};
                if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
            end
            if (state == S_HELD && le_fall) cnt <= '0;
            if (err_set) frame_err <= 1'b1;
        end
    end

    // R1: a sampled bit lands in the word LSB on the next cycle
    assert_msb_first_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && sclk_rise) |=> (word[0] == $past(sdata)));
    // R2 / R9: every latch edge in SHIFT either commits or flags
    assert_latch_resolves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && le_rise) |=> (state == S_HELD));
    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
    import scfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [WORD_W-1:0]       word,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_en,
    output logic [NCH*DIV_W-1:0]    ch_div,
    output logic [NCH*DLY_W-1:0]    ch_dly,
    output logic                    in_sel,
    output logic                    glob_en,
    output logic                    pwr_down,
    output logic                    vboost
);
    chan_cfg_t [NCH-1:0] ch_q;
    glob_cfg_t           glb_q;
    logic                vb_q;

    logic [ADDR_W-1:0] addr;
    logic              is_chan, soft_rst, known_addr;
    chan_cfg_t         new_ch;

    assign addr     = word[ADDR_W-1:0];
    assign is_chan  = (32'(addr) < NCH);
    assign soft_rst = wr_stb && (addr == '0) && word[SRST_BIT];
    assign known_addr = is_chan || (addr == VB_ADDR) || (addr == GLB_ADDR);
    assign new_ch   = '{mode: word[MODE_LSB +: MODE_W], en: word[EN_BIT],
                        div: word[DIV_LSB +: DIV_W], dly: word[DLY_LSB +: DLY_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= {NCH{CHAN_DEFAULT}};
            glb_q <= GLOB_DEFAULT;
            vb_q  <= 1'b0;
        end else if (soft_rst) begin
            ch_q  <= {NCH{CHAN_DEFAULT}};
            glb_q <= GLOB_DEFAULT;
            vb_q  <= 1'b0;
        end else if (wr_stb) begin
            if (is_chan) ch_q[addr[$clog2(NCH)-1:0]] <= new_ch;
            else if (addr == VB_ADDR) vb_q <= word[VB_BIT];
            else if (addr == GLB_ADDR)
                glb_q <= '{insel: word[INSEL_BIT], gen: word[GEN_BIT], pd: word[PD_BIT]};
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign ch_mode[g*MODE_W +: MODE_W] = ch_q[g].mode;
        assign ch_en[g]                    = ch_q[g].en;
        assign ch_div[g*DIV_W +: DIV_W]    = ch_q[g].div;
        assign ch_dly[g*DLY_W +: DLY_W]    = ch_q[g].dly;
    end

    assign in_sel   = glb_q.insel;
    assign glob_en  = glb_q.gen;
    assign pwr_down = glb_q.pd;
    assign vboost   = vb_q;

    // R7: soft reset leaves every channel disabled and global enable on
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ch_en == '0 && glob_en && !pwr_down && !vboost));
    // R8: unused addresses leave every register as it was
    assert_unused_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !known_addr) |=> ($stable(ch_q) && $stable(glb_q) && $stable(vb_q)));
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import scfg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_latch,
    output logic [NCH*MODE_W-1:0]  ch_mode,
    output logic [NCH-1:0]         ch_en,
    output logic [NCH*DIV_W-1:0]   ch_div,
    output logic [NCH*DLY_W-1:0]   ch_dly,
    output logic                   in_sel,
    output logic                   glob_en,
    output logic                   pwr_down,
    output logic                   vboost,
    output logic                   frame_err
);
    logic [2:0] lvl, rise, fall;
    logic [WORD_W-1:0] word;
    logic wr_stb;

    scfg_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_latch, ser_data, ser_clk}),
        .level(lvl), .rise(rise), .fall(fall)
    );

    scfg_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(rise[0]), .sdata(lvl[1]),
        .le_rise(rise[2]), .le_fall(fall[2]),
        .word(word), .wr_stb(wr_stb), .frame_err(frame_err)
    );

    scfg_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .word(word),
        .ch_mode(ch_mode), .ch_en(ch_en), .ch_div(ch_div), .ch_dly(ch_dly),
        .in_sel(in_sel), .glob_en(glob_en), .pwr_down(pwr_down), .vboost(vboost)
    );
endmodule

// File: tb/test_serial_cfg_bank.sv
module test_serial_cfg_bank;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic [NCH*2-1:0] ch_mode;
    logic [NCH-1:0]   ch_en;
    logic [NCH*8-1:0] ch_div;
    logic [NCH*4-1:0] ch_dly;
    logic in_sel, glob_en, pwr_down, vboost, frame_err;

    always #10 clk = ~clk;

    serial_cfg_bank i_serial_cfg_bank (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ch_mode(ch_mode), .ch_en(ch_en), .ch_div(ch_div),
        .ch_dly(ch_dly), .in_sel(in_sel), .glob_en(glob_en), .pwr_down(pwr_down),
        .vboost(vboost), .frame_err(frame_err)
    );

    typedef struct {
        logic [NCH*2-1:0] mode;
        logic [NCH-1:0]   en;
        logic [NCH*8-1:0] dv;
        logic [NCH*4-1:0] dl;
        logic [3:0]       glb;
        logic             err;
        string            req;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model
    logic [NCH*2-1:0] m_mode;
    logic [NCH-1:0]   m_en;
    logic [NCH*8-1:0] m_div;
    logic [NCH*4-1:0] m_dly;
    logic m_insel, m_gen, m_pd, m_vb, m_err;

    task automatic model_defaults();
        m_mode = '0; m_en = '0; m_dly = '0;
        for (int i = 0; i < NCH; i++) m_div[i*8 +: 8] = 8'd1;
        m_insel = 0; m_gen = 1; m_pd = 0; m_vb = 0;
    endtask

    task automatic model_apply(input logic [31:0] w, input int nbits);
        int a;
        if (nbits < 32) begin m_err = 1; return; end
        a = int'(w[3:0]);
        if (a == 0 && w[31]) model_defaults();
        else if (a < NCH) begin
            m_mode[a*2 +: 2] = w[18:17];
            m_en[a]          = w[16];
            m_div[a*8 +: 8]  = w[15:8];
            m_dly[a*4 +: 4]  = w[7:4];
        end else if (a == 9) m_vb = w[16];
        else if (a == 14) begin m_insel = w[28]; m_gen = w[27]; m_pd = w[26]; end
    endtask

    task automatic push_expect(input string req);
        exp_t e;
        e.mode = m_mode; e.en = m_en; e.dv = m_div; e.dl = m_dly;
        e.glb = {m_insel, m_gen, m_pd, m_vb}; e.err = m_err; e.req = req;
        q.push_back(e);
        ->chk_ev;
        repeat (4) @(negedge clk);
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    // Driver: shift nbits of val MSB first, then pulse the latch
    task automatic send(input logic [63:0] val, input int nbits, input string req);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = val[i]; half();
            ser_clk = 1'b1;    half();
            ser_clk = 1'b0;
        end
        half();
        ser_latch = 1'b1; repeat (6) @(negedge clk);
        ser_latch = 1'b0; repeat (4) @(negedge clk);
        model_apply(val[31:0], nbits);
        push_expect(req);
    endtask

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.req, "mode", 64'(ch_mode), 64'(e.mode));
                cmp(e.req, "en",   64'(ch_en),   64'(e.en));
                cmp(e.req, "div",  ch_div,       e.dv);
                cmp(e.req, "dly",  64'(ch_dly),  64'(e.dl));
                cmp(e.req, "glb",  64'({in_sel, glob_en, pwr_down, vboost}), 64'(e.glb));
                cmp(e.req, "err",  64'(frame_err), 64'(e.err));
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_defaults(); m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        push_expect("R6 reset defaults");
        // R1 R2 R3: channel 3, mode 3, enable, div 0x7F, delay 9
        send(64'({13'd0, 2'd3, 1'b1, 8'h7F, 4'd9, 4'd3}), 32, "R1 R2 R3 ch3 write");
        // R3: channel 7 different pattern
        send(64'({13'd0, 2'd2, 1'b0, 8'hC4, 4'd6, 4'd7}), 32, "R3 ch7 write");
        // R4: global, insel 1, gen 0, pd 1
        send(64'({3'b0, 1'b1, 1'b0, 1'b1, 22'd0, 4'd14}), 32, "R4 global write");
        // R5: boost bit 16 at address 9
        send(64'({15'd0, 1'b1, 12'd0, 4'd9}), 32, "R5 boost write");
        // R8: all ones to unused address 12 and 8
        send(64'({28'hFFF_FFFF, 4'd12}), 32, "R8 unused addr 12");
        send(64'({28'hFFF_FFFF, 4'd8}), 32, "R8 unused addr 8");
        // R9: short frame to channel 1 rejected
        send(64'({13'd0, 2'd1, 1'b1, 8'h33, 4'd5, 4'd1}), 31, "R9 short frame");
        // R10: 40-bit frame, last 32 bits address channel 5
        send({24'd0, 8'hA5, 13'd0, 2'd1, 1'b1, 8'h5A, 4'd12, 4'd5}, 40, "R10 long frame");
        // R7: soft reset with other fields set, error stays sticky (R9)
        send(64'({1'b1, 12'd0, 2'd3, 1'b1, 8'hEE, 4'd15, 4'd0}), 32, "R7 soft reset");
        // R3: channel 0 normal write after reset
        send(64'({13'd0, 2'd1, 1'b1, 8'h02, 4'd3, 4'd0}), 32, "R3 ch0 write");
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule